// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This unit holds the interrupt logic of a small serial port. It watches two conditions from the port's FIFOs. The first is a receive FIFO that holds data. The second is a transmit FIFO that has drained to a low-water mark. The low-water mark is reached while a few entries are still queued, so this source means "nearly empty" rather than "fully empty". Each condition sets a sticky flag in a raw status register. Software clears a flag by writing a 1 to its bit, usually by writing back the value it has just read.

A per-source enable register selects which flags can raise the interrupt. A separate global host-enable bit in the control register gates the final output, whatever the per-source enables hold. The single interrupt line toward the host is a registered level. The FIFOs are not part of this unit: a receive-not-empty level and a transmit fill-level count stand in for them. Register access uses a plain synchronous write port and a combinational read port.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset, the status register, the enable register, the host-enable bit and `irq` all read 0.
- R2: Status bit 0 (receive flag) is 1 on the cycle after `rx_not_empty` is seen high at a clock edge.
- R3: Status bit 1 (transmit low-water flag) is set when `tx_level` is 4 or less at a clock edge. A level of 5 or more does not set it.
- R4: A write to address 0 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. The clear takes priority in the cycle of the write.
- R5: If a source condition is still true after its flag was cleared, the flag reads 1 again one cycle after the clear.
- R6: A set status bit stays 1 until it is cleared, even after its condition goes away, and it is set whatever the enable register holds.
- R7: The enable register at address 1 (bit 0 for receive, bit 1 for transmit low-water) masks each source. Writing 0 to it keeps `irq` low.
- R8: Bit 0 of the control register at address 2 is the host enable. While it is 0, `irq` is low one cycle later, whatever the flags and enables hold.
- R9: `irq` is a register. It equals host enable AND the OR of (status AND enable), taken from the previous cycle.
- R10: Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 control) |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 2 | Write data |
| reg_rdata | output | 2 | Read data for `reg_addr`, combinational |
| rx_not_empty | input | 1 | Receive FIFO holds at least one entry |
| tx_level | input | 5 | Transmit FIFO fill count, 0 to 16 |
| irq | output | 1 | Level interrupt toward the host |

## Verification
The properties assume a synchronous register port: `reg_we` and its address and data are stable around each edge, and `tx_level` never exceeds the FIFO depth. They also assume that the reset is held for several cycles, so the checker's one-cycle history starts from reset values. The stimulus changes all inputs only on falling clock edges and keeps `tx_level` within 0 to 16. It parks `tx_level` at the full count whenever the transmit source must stay quiet, so only the intended flag moves during each step.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int ADDR_W  = 2;
    localparam int SRC_N   = 2;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

    typedef enum int {
        SRC_RX    = 0,
        SRC_TXLOW = 1
    } src_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic status_w;
        logic enable_w;
        logic ctrl_w;
    } reg_wr_t;

    function automatic reg_wr_t decode_write(input logic we, input logic [ADDR_W-1:0] addr);
        reg_wr_t r;
        r.status_w = we && (addr == ADDR_STATUS);
        r.enable_w = we && (addr == ADDR_ENABLE);
        r.ctrl_w   = we && (addr == ADDR_CTRL);
        return r;
    endfunction

    function automatic logic any_pending(input src_vec_t st, input src_vec_t en, input logic host);
        return host && (|(st & en));
    endfunction

endpackage

// File: rtl/uirq_cond.sv
module uirq_cond
    import uirq_pkg::*;
#(
    parameter int TX_DEPTH   = 16,
    parameter int TX_LOW_MAX = 4,
    localparam int LVL_W     = $clog2(TX_DEPTH + 1)
) (
    input  logic             rx_not_empty,
    input  logic [LVL_W-1:0] tx_level,
    output src_vec_t         cond
);
    localparam logic [LVL_W-1:0] LOW_MARK = LVL_W'(TX_LOW_MAX);

    always_comb begin
        cond            = '0;
        cond[SRC_RX]    = rx_not_empty;
        cond[SRC_TXLOW] = (tx_level <= LOW_MARK);
    end
endmodule

// File: rtl/uirq_status.sv
module uirq_status
    import uirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t cond,
    input  logic     clr_we,
    input  src_vec_t clr_mask,
    output src_vec_t status
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= 1'b0;
            end else if (clr_we && clr_mask[i]) begin
                status[i] <= 1'b0;
            end else if (cond[i]) begin
                status[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic [ADDR_W-1:0] addr,
    input  src_vec_t          wdata,
    input  src_vec_t          status,
    output src_vec_t          enable,
    output logic              host_en,
    output src_vec_t          rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable  <= '0;
            host_en <= 1'b0;
        end else begin
            if (wr.enable_w) enable  <= wdata;
            if (wr.ctrl_w)   host_en <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_STATUS: rdata = status;
            ADDR_ENABLE: rdata = enable;
            ADDR_CTRL:   rdata[0] = host_en;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int TX_DEPTH   = 16,
    parameter int TX_LOW_MAX = 4,
    localparam int LVL_W     = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [SRC_N-1:0]  reg_wdata,
    output logic [SRC_N-1:0]  reg_rdata,
    input  logic              rx_not_empty,
    input  logic [LVL_W-1:0]  tx_level,
    output logic              irq
);
    reg_wr_t  wr;
    src_vec_t cond;
    src_vec_t status_q;
    src_vec_t enable_q;
    logic     host_en_q;

    assign wr = decode_write(reg_we, reg_addr);

    uirq_cond #(
        .TX_DEPTH  (TX_DEPTH),
        .TX_LOW_MAX(TX_LOW_MAX)
    ) cond_i (
        .rx_not_empty(rx_not_empty),
        .tx_level    (tx_level),
        .cond        (cond)
    );

    uirq_status status_i (
        .clk     (clk),
        .rst     (rst),
        .cond    (cond),
        .clr_we  (wr.status_w),
        .clr_mask(reg_wdata),
        .status  (status_q)
    );

    uirq_regs regs_i (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .status (status_q),
        .enable (enable_q),
        .host_en(host_en_q),
        .rdata  (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= any_pending(status_q, enable_q, host_en_q);
    end
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk
    import uirq_pkg::*;
#(
    parameter int TX_DEPTH   = 16,
    parameter int TX_LOW_MAX = 4,
    localparam int LVL_W     = $clog2(TX_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [SRC_N-1:0]  reg_wdata,
    input logic              rx_not_empty,
    input logic [LVL_W-1:0]  tx_level,
    input logic [SRC_N-1:0]  status,
    input logic [SRC_N-1:0]  enable,
    input logic              host_en,
    input logic              irq
);
    logic [SRC_N-1:0] clr;
    logic             tx_low;

    assign clr    = (reg_we && reg_addr == ADDR_STATUS) ? reg_wdata : '0;
    assign tx_low = (tx_level <= LVL_W'(TX_LOW_MAX));

    // R4: a written 1 clears the flag at the next edge
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
            clr[i] |=> !status[i]);
        // R6: flags are sticky until cleared
        p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            status[i] && !clr[i] |=> status[i]);
    end

    p_rx_set_r2: assert property (@(posedge clk) disable iff (rst)
        rx_not_empty && !clr[SRC_RX] |=> status[SRC_RX]);

    p_tx_set_r3: assert property (@(posedge clk) disable iff (rst)
        tx_low && !clr[SRC_TXLOW] |=> status[SRC_TXLOW]);

    p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
        (clr[SRC_RX] && rx_not_empty) ##1 (rx_not_empty && !clr[SRC_RX]) |=> status[SRC_RX]);

    p_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |=> !irq);

    p_host_r8: assert property (@(posedge clk) disable iff (rst)
        !host_en |=> !irq);

    p_irq_reg_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(host_en && (|(status & enable)))));
endmodule

bind uirq_ctrl uirq_ctrl_chk #(
    .TX_DEPTH  (TX_DEPTH),
    .TX_LOW_MAX(TX_LOW_MAX)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .rx_not_empty(rx_not_empty),
    .tx_level    (tx_level),
    .status      (status_q),
    .enable      (enable_q),
    .host_en     (host_en_q),
    .irq         (irq)
);

// File: tb/uirq_ctrl_tb_top.sv
module uirq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_wdata = 2'd0;
    logic [1:0] reg_rdata;
    logic       rx_not_empty = 1'b0;
    logic [4:0] tx_level = 5'd16;
    logic       irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    typedef struct {
        string      req;
        logic [1:0] addr;
        logic [1:0] data;
        logic       irq;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    uirq_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .rx_not_empty(rx_not_empty),
        .tx_level    (tx_level),
        .irq         (irq)
    );

    // monitor: pops expected items and compares just after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (reg_rdata !== e.data || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s addr=%0d rdata=%0h irq=%0b expected rdata=%0h irq=%0b",
                             e.req, e.addr, reg_rdata, irq, e.data, e.irq);
                end
            end
        end
    end

    task automatic chk_now(string req, logic [1:0] a, logic [1:0] d, logic i);
        exp_t e;
        reg_addr = a;
        e.req = req; e.addr = a; e.data = d; e.irq = i;
        q.push_back(e);
    endtask

    task automatic chk(string req, logic [1:0] a, logic [1:0] d, logic i);
        @(negedge clk);
        chk_now(req, a, d, i);
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = 2'd0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 status", 2'd0, 2'd0, 1'b0);
        chk("R1 enable", 2'd1, 2'd0, 1'b0);
        chk("R1 ctrl",   2'd2, 2'd0, 1'b0);

        @(negedge clk); rx_not_empty = 1'b1;
        chk("R2 rx flag set, R6 while masked", 2'd0, 2'd1, 1'b0);
        rx_not_empty = 1'b0;
        chk("R6 flag sticky", 2'd0, 2'd1, 1'b0);

        wr(2'd0, 2'd0); chk_now("R4 write zero keeps", 2'd0, 2'd1, 1'b0);
        wr(2'd0, 2'd1); chk_now("R4 write one clears", 2'd0, 2'd0, 1'b0);

        tx_level = 5'd5;
        chk("R3 level 5 no set", 2'd0, 2'd0, 1'b0);
        chk("R3 level 5 no set", 2'd0, 2'd0, 1'b0);
        tx_level = 5'd4;
        chk("R3 level 4 sets", 2'd0, 2'd2, 1'b0);
        tx_level = 5'd16;
        wr(2'd0, 2'd2); chk_now("R3 clear tx flag", 2'd0, 2'd0, 1'b0);

        rx_not_empty = 1'b1;
        chk("R5 set", 2'd0, 2'd1, 1'b0);
        wr(2'd0, 2'd1); chk_now("R5 clear wins", 2'd0, 2'd0, 1'b0);
        chk("R5 re-set", 2'd0, 2'd1, 1'b0);
        rx_not_empty = 1'b0;
        wr(2'd0, 2'd1); chk_now("R4 cleared", 2'd0, 2'd0, 1'b0);

        wr(2'd2, 2'd1); chk_now("R8 host enable", 2'd2, 2'd1, 1'b0);
        rx_not_empty = 1'b1;
        chk("R7 not enabled", 2'd0, 2'd1, 1'b0);
        wr(2'd1, 2'd1); chk_now("R9 latency", 2'd1, 2'd1, 1'b0);
        chk("R9 irq raised", 2'd1, 2'd1, 1'b1);
        wr(2'd1, 2'd0);
        chk("R7 all disabled", 2'd1, 2'd0, 1'b0);
        wr(2'd1, 2'd2);
        chk("R7 other source only", 2'd1, 2'd2, 1'b0);
        wr(2'd1, 2'd3);
        chk("R7 both enabled", 2'd1, 2'd3, 1'b1);
        wr(2'd2, 2'd0); chk_now("R8 registered", 2'd2, 2'd0, 1'b1);
        chk("R8 host gates", 2'd2, 2'd0, 1'b0);
        chk("R6 polled while gated", 2'd0, 2'd1, 1'b0);

        wr(2'd3, 2'd3);
        chk("R10 addr3 reads 0", 2'd3, 2'd0, 1'b0);
        chk("R10 enable kept", 2'd1, 2'd3, 1'b0);
        chk("R10 ctrl kept", 2'd2, 2'd0, 1'b0);

        wr(2'd2, 2'd1);
        rx_not_empty = 1'b0;
        wr(2'd0, 2'd1);
        chk("R4 irq drops after clear", 2'd0, 2'd0, 1'b0);
        tx_level = 5'd0;
        chk("R3 empty sets", 2'd0, 2'd2, 1'b0);
        chk("R9 tx irq", 2'd0, 2'd2, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule